// File: doc/BRIEF.md
# Battery Temperature Zone Profiler

The profiler takes a signed battery temperature and places it in one of seven charging zones. The zone boundaries are six thresholds. Two 3-bit selector codes pick them from fixed sets: one code for the cold side and one for the warm side. For the zone it finds, the block computes the charge-current code and the charge-voltage code that the charger regulation loops should use. It also raises a charge-suspend request whenever charging must stop.

Temperature arrives in signed half-degree units, so code 50 means 25.0 °C. The base current and base voltage codes come from the charger's own settings. The voltage code is 10 mV per step.

Per-zone current settings can scale the base current to 20 % or 40 %, or suspend charging. Per-zone voltage settings lower the regulation target by 10, 20 or 30 codes. An ignore input forces the normal zone. A bias-fault input reports a dedicated fault code.

All outputs are registered and follow the inputs one clock later. A one-cycle event marks every change of the reported zone.

Top module: `temp_zone_profiler`

## Requirements
- R1: While `rst` is sampled high at a rising edge, all outputs become zero on that edge. Zero is the normal zone code.
- R2: The cold-side code `cold_set` selects the first, second and third thresholds in °C: 0 gives 0/5/15, 1 gives 0/10/15, 2 gives 0/15/20, 3 gives 0/20/20, 4 gives -5/5/15, 5 gives -5/10/15, 6 gives -5/10/20 and 7 gives 0/10/20.
- R3: The warm-side code `hot_set` selects the fourth, fifth and sixth thresholds in °C: 0 gives 35/40/60, 1 gives 35/45/60, 2 gives 35/50/60, 3 gives 40/55/60, 4 gives 35/40/50, 5 gives 35/45/50, 6 gives 40/45/60 and 7 gives 40/50/60.
- R4: With temperature t and thresholds T1..T6, each scaled by 2, `zone_o` is assigned as follows:
  - 1 (cold) when t < T1
  - 3 (cool) when T1 ≤ t < T2
  - 5 (precool) when T2 ≤ t < T3
  - 0 (normal) when T3 ≤ t ≤ T4
  - 6 (prewarm) when T4 < t ≤ T5
  - 4 (warm) when T5 < t ≤ T6
  - 2 (hot) when t > T6
- R5: When `ts_ignore` is 1, the zone is 0, `suspend_o` is 0 and `ichg_o` equals `ichg_base`, whatever the temperature and bias-fault inputs are.
- R6: When `bias_fault` is 1 and `ts_ignore` is 0, the zone is 7 regardless of temperature.
- R7: `suspend_o` is 1 and `ichg_o` is 0 in zones 1, 2 and 7, and in any of zones 3, 5, 4 and 6 whose current setting is 0. Zones 3, 5, 4 and 6 take their current setting from `iset_cool`, `iset_precool`, `iset_warm` and `iset_prewarm` respectively.
- R8: A current setting of 1 gives floor(base/5) and a setting of 2 gives floor(2·base/5). A setting of 3, or zone 0, passes the base current through unchanged.
- R9: In zone 4 the voltage setting is `vset_warm`; in zone 6 it is `vset_prewarm`. Setting k lowers `vreg_o` to `vreg_base` − (3−k)·10, clamped at 0.
- R10: With `vset_mirror` at 1, zone 3 uses `vset_warm` and zone 5 uses `vset_prewarm`. With `vset_mirror` at 0, both zones output `vreg_base`. Zones 0, 1, 2 and 7 always output `vreg_base`.
- R11: `zone_chg_o` is 1 for exactly the cycles in which `zone_o` differs from its value one cycle earlier.
- R12: Every output reflects the inputs sampled at the preceding rising edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_in | input | TEMP_W | Signed temperature, 0.5 °C per code |
| cold_set | input | 3 | Cold-side threshold set select |
| hot_set | input | 3 | Warm-side threshold set select |
| iset_cool | input | 2 | Current setting for zone 3 |
| iset_precool | input | 2 | Current setting for zone 5 |
| iset_warm | input | 2 | Current setting for zone 4 |
| iset_prewarm | input | 2 | Current setting for zone 6 |
| vset_warm | input | 2 | Voltage setting for zone 4 |
| vset_prewarm | input | 2 | Voltage setting for zone 6 |
| vset_mirror | input | 1 | Apply warm-side voltage settings to the cool side |
| ts_ignore | input | 1 | Force normal zone |
| bias_fault | input | 1 | Sensor bias reference fault |
| ichg_base | input | ICHG_W | Base charge-current code |
| vreg_base | input | VREG_W | Base charge-voltage code, 10 mV per code |
| zone_o | output | 3 | Registered zone code |
| zone_chg_o | output | 1 | One-cycle zone change event |
| suspend_o | output | 1 | Charge-suspend request |
| ichg_o | output | ICHG_W | Effective charge-current code |
| vreg_o | output | VREG_W | Effective charge-voltage code |

## Verification
The zone-change event and the charge-suspend request can switch on the same edge. This happens when the temperature steps from a normal or scaled zone straight into cold or hot, or when bias fault is raised.

The table walk makes such steps deliberately: it moves from normal to cold and from warm to hot. The directed tests move from normal to bias fault. On each such edge the bench checks all of the following together:
- the event bit
- the new zone
- the suspend bit
- the zeroed current

Holding the inputs for one more cycle then confirms that the event drops while the suspend request stays high.

// File: rtl/tzp_pkg.sv
package tzp_pkg;
  typedef enum logic [2:0] {
    ZN_NORMAL  = 3'd0,
    ZN_COLD    = 3'd1,
    ZN_HOT     = 3'd2,
    ZN_COOL    = 3'd3,
    ZN_WARM    = 3'd4,
    ZN_PRECOOL = 3'd5,
    ZN_PREWARM = 3'd6,
    ZN_BIASFLT = 3'd7
  } zone_e;

  localparam logic [1:0] ISET_STOP = 2'd0;
  localparam logic [1:0] ISET_P20  = 2'd1;
  localparam logic [1:0] ISET_P40  = 2'd2;
  localparam logic [1:0] ISET_KEEP = 2'd3;
  localparam logic [1:0] VSET_KEEP = 2'd3;
endpackage

// File: rtl/tzp_threshold_sel.sv
module tzp_threshold_sel #(
  parameter int TEMP_W = 10,
  parameter int UNITS_PER_DEG = 2
) (
  input  logic [2:0]               cold_set,
  input  logic [2:0]               hot_set,
  output logic signed [TEMP_W-1:0] th1,
  output logic signed [TEMP_W-1:0] th2,
  output logic signed [TEMP_W-1:0] th3,
  output logic signed [TEMP_W-1:0] th4,
  output logic signed [TEMP_W-1:0] th5,
  output logic signed [TEMP_W-1:0] th6
);
  int c1, c2, c3, h4, h5, h6;

  always_comb begin
    c1 = 0; c2 = 10; c3 = 15;
    case (cold_set)
      3'd0: begin c1 = 0;  c2 = 5;  c3 = 15; end
      3'd1: begin c1 = 0;  c2 = 10; c3 = 15; end
      3'd2: begin c1 = 0;  c2 = 15; c3 = 20; end
      3'd3: begin c1 = 0;  c2 = 20; c3 = 20; end
      3'd4: begin c1 = -5; c2 = 5;  c3 = 15; end
      3'd5: begin c1 = -5; c2 = 10; c3 = 15; end
      3'd6: begin c1 = -5; c2 = 10; c3 = 20; end
      default: begin c1 = 0; c2 = 10; c3 = 20; end
    endcase
  end

  always_comb begin
    h4 = 35; h5 = 45; h6 = 60;
    case (hot_set)
      3'd0: begin h4 = 35; h5 = 40; h6 = 60; end
      3'd1: begin h4 = 35; h5 = 45; h6 = 60; end
      3'd2: begin h4 = 35; h5 = 50; h6 = 60; end
      3'd3: begin h4 = 40; h5 = 55; h6 = 60; end
      3'd4: begin h4 = 35; h5 = 40; h6 = 50; end
      3'd5: begin h4 = 35; h5 = 45; h6 = 50; end
      3'd6: begin h4 = 40; h5 = 45; h6 = 60; end
      default: begin h4 = 40; h5 = 50; h6 = 60; end
    endcase
  end

  assign th1 = TEMP_W'(c1 * UNITS_PER_DEG);
  assign th2 = TEMP_W'(c2 * UNITS_PER_DEG);
  assign th3 = TEMP_W'(c3 * UNITS_PER_DEG);
  assign th4 = TEMP_W'(h4 * UNITS_PER_DEG);
  assign th5 = TEMP_W'(h5 * UNITS_PER_DEG);
  assign th6 = TEMP_W'(h6 * UNITS_PER_DEG);
endmodule

// File: rtl/tzp_zone_classify.sv
module tzp_zone_classify
  import tzp_pkg::*;
#(
  parameter int TEMP_W = 10
) (
  input  logic signed [TEMP_W-1:0] temp,
  input  logic signed [TEMP_W-1:0] th1,
  input  logic signed [TEMP_W-1:0] th2,
  input  logic signed [TEMP_W-1:0] th3,
  input  logic signed [TEMP_W-1:0] th4,
  input  logic signed [TEMP_W-1:0] th5,
  input  logic signed [TEMP_W-1:0] th6,
  input  logic                     ignore,
  input  logic                     bias_fault,
  output zone_e                    zone
);
  always_comb begin
    if (ignore)           zone = ZN_NORMAL;
    else if (bias_fault)  zone = ZN_BIASFLT;
    else if (temp < th1)  zone = ZN_COLD;
    else if (temp < th2)  zone = ZN_COOL;
    else if (temp < th3)  zone = ZN_PRECOOL;
    else if (temp <= th4) zone = ZN_NORMAL;
    else if (temp <= th5) zone = ZN_PREWARM;
    else if (temp <= th6) zone = ZN_WARM;
    else                  zone = ZN_HOT;
  end
endmodule

// File: rtl/tzp_charge_adjust.sv
module tzp_charge_adjust
  import tzp_pkg::*;
#(
  parameter int ICHG_W = 6,
  parameter int VREG_W = 9,
  parameter int VSTEP  = 10,
  parameter int DIVISOR = 5
) (
  input  zone_e              zone,
  input  logic [ICHG_W-1:0]  ichg_base,
  input  logic [VREG_W-1:0]  vreg_base,
  input  logic [1:0]         iset_cool,
  input  logic [1:0]         iset_precool,
  input  logic [1:0]         iset_warm,
  input  logic [1:0]         iset_prewarm,
  input  logic [1:0]         vset_warm,
  input  logic [1:0]         vset_prewarm,
  input  logic               vset_mirror,
  output logic [ICHG_W-1:0]  ichg_adj,
  output logic [VREG_W-1:0]  vreg_adj,
  output logic               suspend
);
  localparam int PW = ICHG_W + 2;

  logic [1:0]        iset;
  logic              hard_stop;
  logic [PW-1:0]     one_fifth;
  logic [PW-1:0]     two_fifth;
  logic [1:0]        vsel;
  logic [VREG_W-1:0] vdrop;

  always_comb begin
    hard_stop = 1'b0;
    iset      = ISET_KEEP;
    case (zone)
      ZN_COOL:    iset = iset_cool;
      ZN_PRECOOL: iset = iset_precool;
      ZN_WARM:    iset = iset_warm;
      ZN_PREWARM: iset = iset_prewarm;
      ZN_NORMAL:  iset = ISET_KEEP;
      default:    hard_stop = 1'b1;
    endcase
  end

  assign one_fifth = {2'b00, ichg_base} / PW'(DIVISOR);
  assign two_fifth = {1'b0, ichg_base, 1'b0} / PW'(DIVISOR);

  always_comb begin
    suspend  = hard_stop || (iset == ISET_STOP);
    ichg_adj = ichg_base;
    if (suspend)               ichg_adj = '0;
    else if (iset == ISET_P20) ichg_adj = ICHG_W'(one_fifth);
    else if (iset == ISET_P40) ichg_adj = ICHG_W'(two_fifth);
  end

  always_comb begin
    case (zone)
      ZN_WARM:    vsel = vset_warm;
      ZN_PREWARM: vsel = vset_prewarm;
      ZN_COOL:    vsel = vset_mirror ? vset_warm : VSET_KEEP;
      ZN_PRECOOL: vsel = vset_mirror ? vset_prewarm : VSET_KEEP;
      default:    vsel = VSET_KEEP;
    endcase
  end

  assign vdrop    = VREG_W'((3 - int'(vsel)) * VSTEP);
  assign vreg_adj = (vreg_base > vdrop) ? (vreg_base - vdrop) : '0;
endmodule

// File: rtl/temp_zone_profiler.sv
module temp_zone_profiler
  import tzp_pkg::*;
#(
  parameter int TEMP_W = 10,
  parameter int ICHG_W = 6,
  parameter int VREG_W = 9,
  parameter int UNITS_PER_DEG = 2,
  parameter int VSTEP = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [TEMP_W-1:0] temp_in,
  input  logic [2:0]               cold_set,
  input  logic [2:0]               hot_set,
  input  logic [1:0]               iset_cool,
  input  logic [1:0]               iset_precool,
  input  logic [1:0]               iset_warm,
  input  logic [1:0]               iset_prewarm,
  input  logic [1:0]               vset_warm,
  input  logic [1:0]               vset_prewarm,
  input  logic                     vset_mirror,
  input  logic                     ts_ignore,
  input  logic                     bias_fault,
  input  logic [ICHG_W-1:0]        ichg_base,
  input  logic [VREG_W-1:0]        vreg_base,
  output logic [2:0]               zone_o,
  output logic                     zone_chg_o,
  output logic                     suspend_o,
  output logic [ICHG_W-1:0]        ichg_o,
  output logic [VREG_W-1:0]        vreg_o
);
  logic signed [TEMP_W-1:0] th1, th2, th3, th4, th5, th6;
  zone_e             zone_d, zone_q;
  logic [ICHG_W-1:0] ichg_d;
  logic [VREG_W-1:0] vreg_d;
  logic              susp_d;

  tzp_threshold_sel #(.TEMP_W(TEMP_W), .UNITS_PER_DEG(UNITS_PER_DEG)) u_thr (
    .cold_set(cold_set), .hot_set(hot_set),
    .th1(th1), .th2(th2), .th3(th3), .th4(th4), .th5(th5), .th6(th6)
  );

  tzp_zone_classify #(.TEMP_W(TEMP_W)) u_cls (
    .temp(temp_in), .th1(th1), .th2(th2), .th3(th3), .th4(th4), .th5(th5), .th6(th6),
    .ignore(ts_ignore), .bias_fault(bias_fault), .zone(zone_d)
  );

  tzp_charge_adjust #(.ICHG_W(ICHG_W), .VREG_W(VREG_W), .VSTEP(VSTEP)) u_adj (
    .zone(zone_d), .ichg_base(ichg_base), .vreg_base(vreg_base),
    .iset_cool(iset_cool), .iset_precool(iset_precool),
    .iset_warm(iset_warm), .iset_prewarm(iset_prewarm),
    .vset_warm(vset_warm), .vset_prewarm(vset_prewarm), .vset_mirror(vset_mirror),
    .ichg_adj(ichg_d), .vreg_adj(vreg_d), .suspend(susp_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      zone_q     <= ZN_NORMAL;
      zone_chg_o <= 1'b0;
      suspend_o  <= 1'b0;
      ichg_o     <= '0;
      vreg_o     <= '0;
    end else begin
      zone_q     <= zone_d;
      zone_chg_o <= (zone_d != zone_q);
      suspend_o  <= susp_d;
      ichg_o     <= ichg_d;
      vreg_o     <= vreg_d;
    end
  end

  assign zone_o = zone_q;
endmodule

// File: rtl/tzp_checker.sv
module tzp_checker #(
  parameter int ICHG_W = 6,
  parameter int VREG_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              ts_ignore,
  input logic [ICHG_W-1:0] ichg_base,
  input logic [VREG_W-1:0] vreg_base,
  input logic [2:0]        zone_o,
  input logic              zone_chg_o,
  input logic              suspend_o,
  input logic [ICHG_W-1:0] ichg_o,
  input logic [VREG_W-1:0] vreg_o
);
  AST_SUSPEND_NO_CURRENT: assert property (@(posedge clk) disable iff (rst)
    suspend_o |-> (ichg_o == '0)); // R7
  AST_FATAL_ZONE_SUSPENDS: assert property (@(posedge clk) disable iff (rst)
    (zone_o == 3'd1 || zone_o == 3'd2 || zone_o == 3'd7) |-> suspend_o); // R7
  AST_EVENT_MATCHES_CHANGE: assert property (@(posedge clk) disable iff (rst)
    zone_chg_o == (zone_o != $past(zone_o))); // R11
  AST_IGNORE_FORCES_NORMAL: assert property (@(posedge clk) disable iff (rst)
    ts_ignore |=> (zone_o == 3'd0 && !suspend_o)); // R5
  AST_NORMAL_PASSES_BASE: assert property (@(posedge clk) disable iff (rst)
    (zone_o == 3'd0 && !$past(rst)) |-> (ichg_o == $past(ichg_base) && !suspend_o)); // R8
  AST_VREG_NOT_RAISED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vreg_o <= $past(vreg_base))); // R9
endmodule

bind temp_zone_profiler tzp_checker #(.ICHG_W(ICHG_W), .VREG_W(VREG_W)) u_chk (
  .clk(clk), .rst(rst), .ts_ignore(ts_ignore), .ichg_base(ichg_base),
  .vreg_base(vreg_base), .zone_o(zone_o), .zone_chg_o(zone_chg_o),
  .suspend_o(suspend_o), .ichg_o(ichg_o), .vreg_o(vreg_o)
);

// File: tb/temp_zone_profiler_tb.sv
`timescale 1ns/1ps
module temp_zone_profiler_tb;
  localparam int TEMP_W = 10;
  localparam int ICHG_W = 6;
  localparam int VREG_W = 9;
  localparam int NV = 29;

  // {temperature (0.5 C units), cold_set, hot_set, expected zone}
  localparam int VEC [NV][4] = '{
    '{50, 1, 1, 0}, '{-1, 1, 1, 1}, '{0, 1, 1, 3}, '{19, 1, 1, 3},
    '{20, 1, 1, 5}, '{30, 1, 1, 0}, '{70, 1, 1, 0}, '{71, 1, 1, 6},
    '{90, 1, 1, 6}, '{91, 1, 1, 4}, '{120, 1, 1, 4}, '{121, 1, 1, 2},
    '{-10, 4, 1, 3}, '{-11, 4, 1, 1}, '{39, 3, 1, 3}, '{40, 3, 1, 0},
    '{101, 1, 4, 2}, '{100, 1, 4, 4}, '{80, 1, 7, 0}, '{81, 1, 7, 6},
    '{39, 7, 1, 5}, '{29, 2, 1, 3}, '{111, 1, 3, 4}, '{10, 0, 1, 5},
    '{19, 5, 1, 3}, '{35, 6, 1, 5}, '{81, 1, 0, 4}, '{100, 1, 2, 6},
    '{95, 1, 5, 4}
  };

  logic clk = 0;
  logic rst = 1;
  logic signed [TEMP_W-1:0] temp_in = '0;
  logic [2:0] cold_set = 3'd1, hot_set = 3'd1;
  logic [1:0] iset_cool = 2'd1, iset_precool = 2'd2, iset_warm = 2'd2, iset_prewarm = 2'd3;
  logic [1:0] vset_warm = 2'd1, vset_prewarm = 2'd2;
  logic vset_mirror = 1'b1, ts_ignore = 1'b0, bias_fault = 1'b0;
  logic [ICHG_W-1:0] ichg_base = 6'd50;
  logic [VREG_W-1:0] vreg_base = 9'd420;
  logic [2:0] zone_o;
  logic zone_chg_o, suspend_o;
  logic [ICHG_W-1:0] ichg_o;
  logic [VREG_W-1:0] vreg_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  temp_zone_profiler #(.TEMP_W(TEMP_W), .ICHG_W(ICHG_W), .VREG_W(VREG_W)) u_dut (
    .clk(clk), .rst(rst), .temp_in(temp_in), .cold_set(cold_set), .hot_set(hot_set),
    .iset_cool(iset_cool), .iset_precool(iset_precool), .iset_warm(iset_warm),
    .iset_prewarm(iset_prewarm), .vset_warm(vset_warm), .vset_prewarm(vset_prewarm),
    .vset_mirror(vset_mirror), .ts_ignore(ts_ignore), .bias_fault(bias_fault),
    .ichg_base(ichg_base), .vreg_base(vreg_base), .zone_o(zone_o),
    .zone_chg_o(zone_chg_o), .suspend_o(suspend_o), .ichg_o(ichg_o), .vreg_o(vreg_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected results for the table settings: base 50 / 420, mirror on
  function automatic int exp_i(input int z);
    case (z)
      0: return 50; 3: return 10; 5: return 20; 4: return 20; 6: return 50;
      default: return 0;
    endcase
  endfunction
  function automatic int exp_v(input int z);
    case (z)
      3: return 400; 4: return 400; 5: return 410; 6: return 410;
      default: return 420;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev;
    string rq;
    repeat (2) @(negedge clk);
    chk("R1", "zone at reset", zone_o, 0);
    chk("R1", "ichg at reset", ichg_o, 0);
    chk("R1", "vreg at reset", vreg_o, 0);
    chk("R1", "suspend at reset", suspend_o, 0);
    chk("R1", "event at reset", zone_chg_o, 0);
    rst = 0;
    prev = 0;
    for (int i = 0; i < NV; i++) begin
      temp_in  = TEMP_W'(VEC[i][0]);
      cold_set = 3'(VEC[i][1]);
      hot_set  = 3'(VEC[i][2]);
      @(negedge clk);
      rq = (VEC[i][1] != 1) ? "R2" : (VEC[i][2] != 1) ? "R3" : "R4";
      chk(rq, $sformatf("zone vec %0d", i), zone_o, VEC[i][3]);
      chk("R8", $sformatf("ichg vec %0d", i), ichg_o, exp_i(VEC[i][3]));
      chk("R10", $sformatf("vreg vec %0d", i), vreg_o, exp_v(VEC[i][3]));
      chk("R7", $sformatf("suspend vec %0d", i), suspend_o,
          (VEC[i][3] == 1 || VEC[i][3] == 2) ? 1 : 0);
      chk("R11", $sformatf("event vec %0d", i), zone_chg_o, (VEC[i][3] != prev) ? 1 : 0);
      prev = VEC[i][3];
    end

    // ignore overrides a cold reading
    cold_set = 3'd1; hot_set = 3'd1; temp_in = -10'sd50; ts_ignore = 1;
    @(negedge clk);
    chk("R5", "ignore zone", zone_o, 0);
    chk("R5", "ignore ichg", ichg_o, 50);
    chk("R5", "ignore suspend", suspend_o, 0);
    // bias fault: zone change and suspend on the same edge
    ts_ignore = 0; bias_fault = 1; temp_in = 10'sd50;
    @(negedge clk);
    chk("R6", "fault zone", zone_o, 7);
    chk("R7", "fault suspend", suspend_o, 1);
    chk("R7", "fault ichg", ichg_o, 0);
    chk("R11", "fault event", zone_chg_o, 1);
    @(negedge clk);
    chk("R11", "event one cycle", zone_chg_o, 0);
    chk("R7", "suspend held", suspend_o, 1);
    ts_ignore = 1;
    @(negedge clk);
    chk("R6", "ignore beats fault", zone_o, 0);
    // mirror off: cool side keeps base voltage
    ts_ignore = 0; bias_fault = 0; vset_mirror = 0; temp_in = 10'sd10;
    @(negedge clk);
    chk("R10", "cool no mirror vreg", vreg_o, 420);
    chk("R8", "cool ichg 20pct", ichg_o, 10);
    temp_in = 10'sd25;
    @(negedge clk);
    chk("R10", "precool no mirror vreg", vreg_o, 420);
    vset_mirror = 1;
    @(negedge clk);
    chk("R10", "precool mirror vreg", vreg_o, 410);
    // current setting 0 suspends in warm
    iset_warm = 2'd0; temp_in = 10'sd100;
    @(negedge clk);
    chk("R7", "warm stop suspend", suspend_o, 1);
    chk("R7", "warm stop ichg", ichg_o, 0);
    chk("R9", "warm vreg", vreg_o, 400);
    // rounding of scaled current
    ichg_base = 6'd7; iset_warm = 2'd1;
    @(negedge clk);
    chk("R8", "floor 20pct of 7", ichg_o, 1);
    iset_warm = 2'd2;
    @(negedge clk);
    chk("R8", "floor 40pct of 7", ichg_o, 2);
    // voltage clamp at zero
    vreg_base = 9'd15; vset_warm = 2'd0;
    @(negedge clk);
    chk("R9", "vreg clamp", vreg_o, 0);
    vset_warm = 2'd2;
    @(negedge clk);
    chk("R9", "vreg minus 10", vreg_o, 5);
    // latency: output must not move before the next edge
    temp_in = -10'sd50;
    #2;
    chk("R12", "zone before edge", zone_o, 4);
    @(negedge clk);
    chk("R12", "zone after edge", zone_o, 1);
    // synchronous reset mid-run
    rst = 1;
    @(negedge clk);
    chk("R1", "zone after reset", zone_o, 0);
    chk("R1", "suspend after reset", suspend_o, 0);
    chk("R1", "vreg after reset", vreg_o, 0);
    rst = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule